// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Decision

This block keeps the exception part of a floating-point status/control register and decides, per operation, whether the CPU must take a trap. An arithmetic datapath reports each completed operation with a valid strobe. With it comes a five-bit vector of detected exception kinds, a hint saying whether the instruction can round at all, and two operand-class hints: a quiet NaN on a source, or an infinity on a source. Software reads the fields directly and rewrites them through a single-cycle write port.

Three five-bit fields are kept. The cause field shows what the most recent operation raised. The flag field accumulates every kind seen until software clears it. The enable field selects which kinds trap. A mode bit makes quiet-NaN or infinity operands count as invalid operations when invalid trapping is enabled. When an accepted operation raises an enabled kind, the block sends a one-cycle trap request to the CPU. It also raises a halt level to the FPU. The halt stays high until software next writes the register, and operations that arrive while halted are dropped.

Top module: `fpu_xcpt_status`

## Requirements
- R1: After reset, the cause, flag and enable fields and the mode bit read zero, and trap_req and fpu_halt are low.
- R2: A cycle with sw_wr_en high loads the register from sw_wr_data, and the new values are visible on the outputs one cycle later. The layout of sw_wr_data is: cause in [4:0], flag in [9:5], enable in [14:10], mode in [15]. Within every five-bit field, and in op_xcpt, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid.
- R3: Each accepted operation replaces the cause field with exactly the kinds it raised. The cause field becomes zero when the operation raises none.
- R4: Flag bits are set for every kind an accepted operation raises, whether or not a trap follows. They clear only through a software write.
- R5: When op_can_round is low, the overflow, underflow and inexact indications are discarded. They do not reach cause, flag or the trap decision.
- R6: trap_req is high for exactly one cycle, in the cycle after the op_valid of an accepted operation that raised at least one kind whose enable bit was set before that edge. trap_req stays low otherwise.
- R7: fpu_halt rises together with trap_req and stays high until the cycle after a software write. An op_valid that arrives while fpu_halt is high changes neither cause nor flag, and gives no trap.
- R8: When both the mode bit and the invalid enable bit are set, a quiet NaN or infinity on a source operand counts as an invalid-operation exception. With either bit clear, these hints are ignored.
- R9: When a software write and an accepted operation fall in the same cycle, the written values win for cause, enable and mode. The flag field becomes the written flags ORed with the operation's kinds. The trap decision uses the enable value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation status strobe from the datapath |
| op_xcpt | input | 5 | Exception kinds detected by the operation |
| op_can_round | input | 1 | Instruction can produce overflow, underflow or inexact |
| op_qnan_in | input | 1 | A source operand is a quiet NaN |
| op_inf_in | input | 1 | A source operand is an infinity |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_data | input | 16 | Software write value (layout in R2) |
| cause_o | output | 5 | Cause field |
| flag_o | output | 5 | Sticky flag field |
| enable_o | output | 5 | Trap enable field |
| qsig_mode_o | output | 1 | Quiet-NaN/infinity signalling mode bit |
| trap_req | output | 1 | One-cycle trap request to the CPU |
| fpu_halt | output | 1 | Halt level to the FPU datapath |

## Verification
The hardest case to reach is a software write and a trapping operation in the same clock. This is the only moment when the old enable value, the new written fields and the flag OR-in all meet. The bench first arms a known enable value. It then drives sw_wr_en and op_valid in one cycle, writing an enable value that would give the opposite trap decision. The bench checks trap_req, the halt level and all three fields against the written data merged with the operation's kinds. Dropped operations are tested in a similar way: the bench leaves the block halted after a trap, drives an operation that would otherwise change every field, and then looks at the outputs.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
   localparam int unsigned XK_NUM = 5;

   typedef enum int unsigned {
      XK_INEXACT = 0,
      XK_UNDER   = 1,
      XK_OVER    = 2,
      XK_DIVZ    = 3,
      XK_INVALID = 4
   } xkind_e;

   typedef logic [XK_NUM-1:0] xvec_t;

   // kinds that only rounding-capable instructions may report
   localparam xvec_t ROUND_ONLY_MASK = xvec_t'(
      (1 << XK_INEXACT) | (1 << XK_UNDER) | (1 << XK_OVER));
endpackage

// File: rtl/fxs_detect.sv
module fxs_detect
   import fxs_pkg::*;
#(
   parameter int unsigned KIND_W  = 5,
   parameter bit          QSIG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [KIND_W-1:0] op_xcpt,
   input  logic              op_can_round,
   input  logic              op_qnan_in,
   input  logic              op_inf_in,
   input  logic              qsig_mode,
   input  logic              en_invalid,
   output logic [KIND_W-1:0] detected
);
   localparam int unsigned INV_BIT = XK_INVALID;

   logic [KIND_W-1:0] round_gate;
   logic [KIND_W-1:0] gated;
   logic              qsig_hit;

   assign round_gate = op_can_round ? '1 : ~KIND_W'(ROUND_ONLY_MASK);
   assign gated      = op_xcpt & round_gate;

   generate
      if (QSIG_EN) begin : g_qsig
         assign qsig_hit = qsig_mode & en_invalid & (op_qnan_in | op_inf_in);
      end else begin : g_noqsig
         logic unused_q;
         assign unused_q = qsig_mode ^ en_invalid ^ op_qnan_in ^ op_inf_in;
         assign qsig_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      detected          = gated;
      detected[INV_BIT] = gated[INV_BIT] | qsig_hit;
   end

   // R5
   round_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_can_round |-> ((detected & KIND_W'(ROUND_ONLY_MASK)) == '0));

   // R8
   qsig_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!qsig_mode || !en_invalid) |-> (detected[INV_BIT] == op_xcpt[INV_BIT]));
endmodule

// File: rtl/fxs_regs.sv
module fxs_regs
   import fxs_pkg::*;
#(
   parameter int unsigned KIND_W  = 5,
   parameter bit          QSIG_EN = 1'b1,
   localparam int unsigned REG_W  = 3*KIND_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [KIND_W-1:0] detected,
   input  logic              sw_wr_en,
   input  logic [REG_W-1:0]  sw_wr_data,
   output logic [KIND_W-1:0] cause,
   output logic [KIND_W-1:0] flag,
   output logic [KIND_W-1:0] enable,
   output logic              qsig_mode
);
   localparam int unsigned CAUSE_LO = 0;
   localparam int unsigned FLAG_LO  = KIND_W;
   localparam int unsigned EN_LO    = 2*KIND_W;
   localparam int unsigned MODE_BIT = 3*KIND_W;

   logic [KIND_W-1:0] wr_cause, wr_flag, wr_en;
   logic [KIND_W-1:0] flag_base, flag_or;

   assign wr_cause  = sw_wr_data[CAUSE_LO +: KIND_W];
   assign wr_flag   = sw_wr_data[FLAG_LO  +: KIND_W];
   assign wr_en     = sw_wr_data[EN_LO    +: KIND_W];
   assign flag_base = sw_wr_en ? wr_flag : flag;
   assign flag_or   = upd ? detected : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause  <= '0;
         flag   <= '0;
         enable <= '0;
      end else begin
         if (sw_wr_en) begin
            cause  <= wr_cause;
            enable <= wr_en;
         end else if (upd) begin
            cause  <= detected;
         end
         flag <= flag_base | flag_or;
      end
   end

   generate
      if (QSIG_EN) begin : g_mode
         always_ff @(posedge clk) begin
            if (!rst_n)        qsig_mode <= 1'b0;
            else if (sw_wr_en) qsig_mode <= sw_wr_data[MODE_BIT];
         end
      end else begin : g_nomode
         logic unused_m;
         assign unused_m  = sw_wr_data[MODE_BIT];
         assign qsig_mode = 1'b0;
      end
   endgenerate

   // R4
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr_en |=> ((flag & $past(flag)) == $past(flag)));

   // R3
   cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !sw_wr_en && detected == '0) |=> (cause == '0));

   // R4
   flag_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> ((flag & $past(detected)) == $past(detected)));
endmodule

// File: rtl/fxs_trap.sv
module fxs_trap
   import fxs_pkg::*;
#(
   parameter int unsigned KIND_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [KIND_W-1:0] detected,
   input  logic [KIND_W-1:0] enable,
   input  logic              sw_wr_en,
   output logic              op_accept,
   output logic              trap_req,
   output logic              halt
);
   logic hit;

   assign op_accept = op_valid & ~halt;
   assign hit       = op_accept & (|(detected & enable));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_req <= 1'b0;
         halt     <= 1'b0;
      end else begin
         trap_req <= hit;
         halt     <= hit | (halt & ~sw_wr_en);
      end
   end

   // R6
   trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> !trap_req);

   // R6
   trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(op_valid));

   // R7
   halt_with_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trap_req) |-> halt);

   // R7
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !sw_wr_en) |=> halt);
endmodule

// File: rtl/fpu_xcpt_status.sv
module fpu_xcpt_status
   import fxs_pkg::*;
#(
   parameter int unsigned KIND_W  = 5,
   parameter bit          QSIG_EN = 1'b1,
   localparam int unsigned REG_W  = 3*KIND_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [KIND_W-1:0] op_xcpt,
   input  logic              op_can_round,
   input  logic              op_qnan_in,
   input  logic              op_inf_in,
   input  logic              sw_wr_en,
   input  logic [REG_W-1:0]  sw_wr_data,
   output logic [KIND_W-1:0] cause_o,
   output logic [KIND_W-1:0] flag_o,
   output logic [KIND_W-1:0] enable_o,
   output logic              qsig_mode_o,
   output logic              trap_req,
   output logic              fpu_halt
);
   generate
      if (KIND_W != XK_NUM) begin : g_bad_width
         $error("KIND_W must equal the number of exception kinds");
      end
   endgenerate

   logic [KIND_W-1:0] detected;
   logic              op_accept;

   fxs_detect #(.KIND_W(KIND_W), .QSIG_EN(QSIG_EN)) u_detect (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_xcpt      (op_xcpt),
      .op_can_round (op_can_round),
      .op_qnan_in   (op_qnan_in),
      .op_inf_in    (op_inf_in),
      .qsig_mode    (qsig_mode_o),
      .en_invalid   (enable_o[XK_INVALID]),
      .detected     (detected)
   );

   fxs_trap #(.KIND_W(KIND_W)) u_trap (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .detected  (detected),
      .enable    (enable_o),
      .sw_wr_en  (sw_wr_en),
      .op_accept (op_accept),
      .trap_req  (trap_req),
      .halt      (fpu_halt)
   );

   fxs_regs #(.KIND_W(KIND_W), .QSIG_EN(QSIG_EN)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd        (op_accept),
      .detected   (detected),
      .sw_wr_en   (sw_wr_en),
      .sw_wr_data (sw_wr_data),
      .cause      (cause_o),
      .flag       (flag_o),
      .enable     (enable_o),
      .qsig_mode  (qsig_mode_o)
   );

   // R7
   halted_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fpu_halt && !sw_wr_en) |=> ($stable(cause_o) && $stable(flag_o) && !trap_req));
endmodule

// File: tb/test_fpu_xcpt_status.sv
module test_fpu_xcpt_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_xcpt = '0;
   logic        op_can_round = 1'b0;
   logic        op_qnan_in = 1'b0;
   logic        op_inf_in = 1'b0;
   logic        sw_wr_en = 1'b0;
   logic [15:0] sw_wr_data = '0;
   logic [4:0]  cause_o, flag_o, enable_o;
   logic        qsig_mode_o, trap_req, fpu_halt;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   fpu_xcpt_status i_fpu_xcpt_status (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_xcpt(op_xcpt),
      .op_can_round(op_can_round), .op_qnan_in(op_qnan_in), .op_inf_in(op_inf_in),
      .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .cause_o(cause_o),
      .flag_o(flag_o), .enable_o(enable_o), .qsig_mode_o(qsig_mode_o),
      .trap_req(trap_req), .fpu_halt(fpu_halt));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] pack(input logic m, input logic [4:0] en,
                                        input logic [4:0] fl, input logic [4:0] ca);
      return {m, en, fl, ca};
   endfunction

   // inputs change at negedge; outputs of one edge are read at the next negedge
   task automatic sw_write(input logic [15:0] d);
      @(negedge clk);
      sw_wr_en = 1'b1; sw_wr_data = d;
      @(negedge clk);
      sw_wr_en = 1'b0;
   endtask

   task automatic do_op(input logic [4:0] x, input logic rnd, input logic qn, input logic inf);
      @(negedge clk);
      op_valid = 1'b1; op_xcpt = x; op_can_round = rnd; op_qnan_in = qn; op_inf_in = inf;
      @(negedge clk);
      op_valid = 1'b0; op_xcpt = '0; op_qnan_in = 1'b0; op_inf_in = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 cause", cause_o, 0);
      chk("R1 flag", flag_o, 0);
      chk("R1 enable", enable_o, 0);
      chk("R1 mode", qsig_mode_o, 0);
      chk("R1 trap", trap_req, 0);
      chk("R1 halt", fpu_halt, 0);
   endtask

   task automatic t_write();
      sw_write(pack(1'b1, 5'b01010, 5'b00101, 5'b10001));
      chk("R2 cause", cause_o, 5'b10001);
      chk("R2 flag", flag_o, 5'b00101);
      chk("R2 enable", enable_o, 5'b01010);
      chk("R2 mode", qsig_mode_o, 1);
      sw_write('0);
      chk("R2 clear", {qsig_mode_o, enable_o, flag_o, cause_o}, 0);
   endtask

   task automatic t_masked();
      do_op(5'b00101, 1'b1, 1'b0, 1'b0);   // overflow + inexact, nothing enabled
      chk("R3 cause", cause_o, 5'b00101);
      chk("R4 flag", flag_o, 5'b00101);
      chk("R6 no trap", trap_req, 0);
      do_op(5'b01000, 1'b1, 1'b0, 1'b0);   // divide-by-zero
      chk("R3 replace", cause_o, 5'b01000);
      chk("R4 accumulate", flag_o, 5'b01101);
      do_op(5'b00000, 1'b1, 1'b0, 1'b0);
      chk("R3 zero", cause_o, 0);
      chk("R4 sticky", flag_o, 5'b01101);
      sw_write('0);
      chk("R4 sw clear", flag_o, 0);
   endtask

   task automatic t_noround();
      do_op(5'b11111, 1'b0, 1'b0, 1'b0);
      chk("R5 cause", cause_o, 5'b11000);
      chk("R5 flag", flag_o, 5'b11000);
      sw_write(pack(1'b0, 5'b00111, 5'b0, 5'b0));
      do_op(5'b00111, 1'b0, 1'b0, 1'b0);
      chk("R5 no trap", trap_req, 0);
      chk("R5 cause clr", cause_o, 0);
      sw_write('0);
   endtask

   task automatic t_trap();
      sw_write(pack(1'b0, 5'b00100, 5'b0, 5'b0));   // enable overflow
      do_op(5'b00001, 1'b1, 1'b0, 1'b0);            // inexact only: no trap
      chk("R6 disabled kind", trap_req, 0);
      do_op(5'b00101, 1'b1, 1'b0, 1'b0);
      chk("R6 pulse", trap_req, 1);
      chk("R7 halt", fpu_halt, 1);
      chk("R4 flag on trap", flag_o, 5'b00101);
      @(negedge clk);
      chk("R6 one cycle", trap_req, 0);
      chk("R7 halt held", fpu_halt, 1);
      do_op(5'b11010, 1'b1, 1'b0, 1'b0);            // dropped while halted
      chk("R7 cause frozen", cause_o, 5'b00101);
      chk("R7 flag frozen", flag_o, 5'b00101);
      chk("R7 no trap", trap_req, 0);
      sw_write(pack(1'b0, 5'b00100, 5'b00101, 5'b0));
      chk("R7 release", fpu_halt, 0);
      sw_write('0);
   endtask

   task automatic t_qsig();
      sw_write(pack(1'b1, 5'b10000, 5'b0, 5'b0));
      do_op(5'b0, 1'b1, 1'b1, 1'b0);
      chk("R8 qnan trap", trap_req, 1);
      chk("R8 qnan cause", cause_o, 5'b10000);
      sw_write(pack(1'b1, 5'b10000, 5'b0, 5'b0));
      do_op(5'b0, 1'b1, 1'b0, 1'b1);
      chk("R8 inf trap", trap_req, 1);
      sw_write(pack(1'b0, 5'b10000, 5'b0, 5'b0));    // mode off
      do_op(5'b0, 1'b1, 1'b1, 1'b1);
      chk("R8 mode off", trap_req, 0);
      chk("R8 mode off cause", cause_o, 0);
      sw_write(pack(1'b1, 5'b01000, 5'b0, 5'b0));    // invalid not enabled
      do_op(5'b0, 1'b1, 1'b1, 1'b0);
      chk("R8 en off", cause_o, 0);
      chk("R8 en off flag", flag_o, 0);
      sw_write('0);
   endtask

   task automatic t_collide();
      sw_write(pack(1'b0, 5'b01000, 5'b0, 5'b0));    // divide-by-zero enabled
      @(negedge clk);
      op_valid = 1'b1; op_xcpt = 5'b01000; op_can_round = 1'b1;
      sw_wr_en = 1'b1; sw_wr_data = pack(1'b0, 5'b00001, 5'b00010, 5'b00011);
      @(negedge clk);
      op_valid = 1'b0; op_xcpt = '0; sw_wr_en = 1'b0;
      chk("R9 old enable traps", trap_req, 1);
      chk("R9 cause written", cause_o, 5'b00011);
      chk("R9 enable written", enable_o, 5'b00001);
      chk("R9 flag merged", flag_o, 5'b01010);
      sw_write('0);
      // opposite direction: new enable would trap, old one does not
      @(negedge clk);
      op_valid = 1'b1; op_xcpt = 5'b00001;
      sw_wr_en = 1'b1; sw_wr_data = pack(1'b0, 5'b00001, 5'b0, 5'b0);
      @(negedge clk);
      op_valid = 1'b0; op_xcpt = '0; sw_wr_en = 1'b0;
      chk("R9 new enable ignored", trap_req, 0);
      chk("R9 flag kept", flag_o, 5'b00001);
      sw_write('0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_masked();
      t_noround();
      t_trap();
      t_qsig();
      t_collide();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule